// File: doc/BRIEF.md
# Supply-Monitored Reset Sequencer

This block drives the active-low reset for a processor core and its peripherals. It takes the decisions of two supply-voltage comparators and an external active-low reset pin. The comparators live outside the block. One reports that the supply is above an upper trip level and the other reports that it is below a lower trip level. Both arrive unsynchronised and each is passed through a two-flop synchroniser inside the block.

The block keeps a "supply good" state with hysteresis. The state becomes good only when the supply reads above the upper level. It becomes bad only when the supply reads below the lower level. Between the two levels the state holds its last value. Once the state becomes good, reset stays asserted for a further `STRETCH_CYCLES` clock cycles (65536 by default) before it is released. A supply drop or a pin assertion during that stretch restarts the full count.

The pin asserts reset at once, without waiting for a clock edge. Its release is synchronised to the clock. A one-bit cause output records whether the most recent reset came from the supply or from the pin.

Top module: `supply_reset_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, `core_rst_n` is low, and it goes low in the same instant the pin falls, without a clock edge. `rst_cause` then reads 1, meaning external pin.
- R2: After power-up, `core_rst_n` stays low for as long as the supply has not yet read above the upper level. This holds both when only `sup_below_lo` is 1 and when both comparator inputs are 0.
- R3: Suppose `ext_rst_n` is high and settled, and `sup_above_hi` rises before clock edge 1 with `sup_below_lo` at 0. Then `core_rst_n` is still low after edge `STRETCH_CYCLES`+2 and is high after edge `STRETCH_CYCLES`+3.
- R4: Once released, reset stays released while both comparator inputs are 0, which means the supply lies inside the hysteresis band.
- R5: Once released, `sup_below_lo` rising before edge 1 leaves `core_rst_n` high after edge 3 and drives it low after edge 4. At that point `rst_cause` reads 0, meaning supply.
- R6: After a supply-caused reset, the supply returning only into the band (both inputs 0) does not release reset. A later rise of `sup_above_hi` releases it with the timing of R3.
- R7: If the supply drops below the lower level while the stretch is running, the count restarts in full. Release follows the R3 timing measured from the next rise of `sup_above_hi`.
- R8: The rise of `ext_rst_n` passes through a two-flop reset synchroniser. With `sup_above_hi` steady at 1, a rise of `ext_rst_n` before edge 1 leaves `core_rst_n` low after edge `STRETCH_CYCLES`+4 and high after edge `STRETCH_CYCLES`+5.
- R9: A pin pulse during the stretch restarts the full count. Release follows the R8 timing measured from the final rise of the pin.
- R10: When both comparator inputs read 1 at once, the below-lower input wins and reset is asserted as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sup_above_hi | input | 1 | Comparator: supply above the upper level (asynchronous) |
| sup_below_lo | input | 1 | Comparator: supply below the lower level (asynchronous) |
| core_rst_n | output | 1 | Reset to core and peripherals, active low |
| rst_cause | output | 1 | Cause of the last reset: 1 = external pin, 0 = supply |

## Verification
The bench moves the supply into the hysteresis band from both sides, because a design with a single threshold would either assert reset there after a release or release it there after a drop. It counts the exact edge of release after a supply rise and after a pin release. This catches a synchroniser stage too many or too few, and a stretch counter that is one cycle off. It interrupts the stretch with a supply dip and with a pin pulse, since a counter that resumes instead of reloading would release early. It also checks the pin mid-cycle, where a synchronous-only assertion would still show reset released, and it drives both comparators high, where a wrong priority would keep reset released.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

  // Encoding of the last-reset-cause flag
  typedef enum logic {
    CAUSE_SUPPLY = 1'b0,
    CAUSE_PIN    = 1'b1
  } rst_cause_e;

  // Width of a down-counter that must hold the value n-1
  function automatic int cnt_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/srs_reset_sync.sv
// Asynchronous-assert, synchronous-release reset synchroniser.
module srs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/srs_bit_sync.sv
// Multi-flop synchroniser for one asynchronous level.
module srs_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/srs_supply_window.sv
// Hysteresis state: set above the upper level, cleared below the lower.
module srs_supply_window (
  input  logic clk,
  input  logic rst_n,
  input  logic above_s,
  input  logic below_s,
  output logic good_o,
  output logic drop_o
);

  logic good_q;
  logic good_d;

  always_comb begin
    good_d = good_q;
    if (below_s)      good_d = 1'b0;   // below wins over above
    else if (above_s) good_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_q <= 1'b0;
    else        good_q <= good_d;
  end

  assign good_o = good_q;
  assign drop_o = good_q & below_s;

endmodule

// File: rtl/srs_stretch_timer.sv
// Holds reset for STRETCH_CYCLES cycles after the supply turns good.
module srs_stretch_timer
  import supply_reset_pkg::*;
#(
  parameter int STRETCH_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good,
  input  logic drop,
  output logic core_rst_n,
  output logic cause_o
);

  localparam int              CNT_W  = cnt_width(STRETCH_CYCLES);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STRETCH_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             rel_q, rel_d;
  rst_cause_e       cause_q, cause_d;

  always_comb begin
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    rel_d   = rel_q;
    cause_d = cause_q;
    if (!good) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
      rel_d  = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
      rel_d  = 1'b0;
    end else begin
      rel_d  = 1'b1;
    end
    if (drop) cause_d = CAUSE_SUPPLY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RELOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q   <= 1'b0;
      cause_q <= CAUSE_PIN;
    end else begin
      rel_q   <= rel_d;
      cause_q <= cause_d;
    end
  end

  assign core_rst_n = rel_q;
  assign cause_o    = cause_q;

endmodule

// File: rtl/supply_reset_ctrl.sv
// Reset sequencer driven by supply comparators and an external pin.
module supply_reset_ctrl #(
  parameter int STRETCH_CYCLES = 65536,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic sup_above_hi,
  input  logic sup_below_lo,
  output logic core_rst_n,
  output logic rst_cause
);

  logic int_rst_n;
  logic above_s;
  logic below_s;
  logic sup_good;
  logic sup_drop;

  srs_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk     (clk),
    .arst_n  (ext_rst_n),
    .rst_n_o (int_rst_n)
  );

  srs_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_hi (
    .clk   (clk),
    .rst_n (int_rst_n),
    .d     (sup_above_hi),
    .q     (above_s)
  );

  srs_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lo (
    .clk   (clk),
    .rst_n (int_rst_n),
    .d     (sup_below_lo),
    .q     (below_s)
  );

  srs_supply_window u_window (
    .clk     (clk),
    .rst_n   (int_rst_n),
    .above_s (above_s),
    .below_s (below_s),
    .good_o  (sup_good),
    .drop_o  (sup_drop)
  );

  srs_stretch_timer #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (int_rst_n),
    .good       (sup_good),
    .drop       (sup_drop),
    .core_rst_n (core_rst_n),
    .cause_o    (rst_cause)
  );

endmodule

// File: rtl/supply_reset_chk.sv
// Property checker bound to the reset sequencer.
module supply_reset_chk #(
  parameter int STRETCH_CYCLES = 65536
) (
  input logic clk,
  input logic ext_rst_n,
  input logic int_rst_n,
  input logic sup_good,
  input logic core_rst_n,
  input logic rst_cause
);

  // Cycles the synchronised supply state has been good without a break
  logic [31:0] good_run;

  always_ff @(posedge clk or negedge int_rst_n) begin
    if (!int_rst_n)             good_run <= '0;
    else if (!sup_good)         good_run <= '0;
    else if (good_run != '1)    good_run <= good_run + 32'd1;
  end

  // R1: pin low always shows as reset at the output
  a_r1_pin_forces_reset : assert property (@(posedge clk)
    !ext_rst_n |-> !core_rst_n);

  // R2: a supply state that is not good keeps reset asserted
  a_r2_hold_while_bad : assert property (@(posedge clk) disable iff (!int_rst_n)
    !sup_good |=> !core_rst_n);

  // R3: release happens exactly after the full stretch of good cycles
  a_r3_full_stretch : assert property (@(posedge clk) disable iff (!int_rst_n)
    $rose(core_rst_n) |-> (good_run == 32'(STRETCH_CYCLES)));

  // R5: a supply drop records the supply as the cause
  a_r5_drop_cause : assert property (@(posedge clk) disable iff (!int_rst_n)
    $fell(sup_good) |-> (rst_cause == 1'b0));

endmodule

bind supply_reset_ctrl supply_reset_chk #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
  .clk        (clk),
  .ext_rst_n  (ext_rst_n),
  .int_rst_n  (int_rst_n),
  .sup_good   (sup_good),
  .core_rst_n (core_rst_n),
  .rst_cause  (rst_cause)
);

// File: tb/test_supply_reset_ctrl.sv
`timescale 1ns/1ps
module test_supply_reset_ctrl;

  localparam int N = 16;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b1;
  logic sup_above_hi = 1'b0;
  logic sup_below_lo = 1'b1;
  logic core_rst_n;
  logic rst_cause;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  supply_reset_ctrl #(.STRETCH_CYCLES(N)) i_supply_reset_ctrl (
    .clk          (clk),
    .ext_rst_n    (ext_rst_n),
    .sup_above_hi (sup_above_hi),
    .sup_below_lo (sup_below_lo),
    .core_rst_n   (core_rst_n),
    .rst_cause    (rst_cause)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic pin, input logic hi, input logic lo);
    @(negedge clk);
    ext_rst_n    = pin;
    sup_above_hi = hi;
    sup_below_lo = lo;
  endtask

  task automatic t_reset_state;
    #1 ext_rst_n = 1'b0;
    edges(3);
    chk("R1", "core_rst_n at reset", core_rst_n, 1'b0);
    chk("R1", "rst_cause at reset", rst_cause, 1'b1);
  endtask

  task automatic t_power_up;
    drive(1'b1, 1'b0, 1'b1);
    edges(40);
    chk("R2", "held below lower level", core_rst_n, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    edges(40);
    chk("R2", "held in band before first good", core_rst_n, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    edges(N + 2);
    chk("R3", "still held one edge before release", core_rst_n, 1'b0);
    edges(1);
    chk("R3", "released after stretch", core_rst_n, 1'b1);
  endtask

  task automatic t_band_hold;
    drive(1'b1, 1'b0, 1'b0);
    edges(50);
    chk("R4", "stays released in band", core_rst_n, 1'b1);
  endtask

  task automatic t_drop;
    drive(1'b1, 1'b0, 1'b1);
    edges(3);
    chk("R5", "not yet asserted after edge 3", core_rst_n, 1'b1);
    edges(1);
    chk("R5", "asserted after edge 4", core_rst_n, 1'b0);
    chk("R5", "cause is supply", rst_cause, 1'b0);
  endtask

  task automatic t_band_no_release;
    drive(1'b1, 1'b0, 1'b0);
    edges(40);
    chk("R6", "band does not release", core_rst_n, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    edges(N + 2);
    chk("R6", "held before stretch end", core_rst_n, 1'b0);
    edges(1);
    chk("R6", "released after stretch", core_rst_n, 1'b1);
  endtask

  task automatic t_restart_supply;
    drive(1'b1, 1'b0, 1'b1);
    edges(10);
    chk("R7", "reset after drop", core_rst_n, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    edges(8);
    drive(1'b1, 1'b0, 1'b1);
    edges(5);
    chk("R7", "held during dip", core_rst_n, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    edges(N + 2);
    chk("R7", "count restarted in full", core_rst_n, 1'b0);
    edges(1);
    chk("R7", "released after full restart", core_rst_n, 1'b1);
  endtask

  task automatic t_pin;
    @(negedge clk);
    ext_rst_n = 1'b0;
    #1;
    chk("R1", "asserted without clock edge", core_rst_n, 1'b0);
    chk("R1", "cause is pin", rst_cause, 1'b1);
    edges(3);
    drive(1'b1, 1'b1, 1'b0);
    edges(N + 4);
    chk("R8", "held before synchronised release", core_rst_n, 1'b0);
    edges(1);
    chk("R8", "released after pin stretch", core_rst_n, 1'b1);
  endtask

  task automatic t_pin_restart;
    drive(1'b0, 1'b1, 1'b0);
    edges(2);
    drive(1'b1, 1'b1, 1'b0);
    edges(6);
    drive(1'b0, 1'b1, 1'b0);
    edges(2);
    chk("R9", "held during second pulse", core_rst_n, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    edges(N + 4);
    chk("R9", "count restarted after pulse", core_rst_n, 1'b0);
    edges(1);
    chk("R9", "released after full restart", core_rst_n, 1'b1);
  endtask

  task automatic t_both;
    drive(1'b1, 1'b1, 1'b1);
    edges(3);
    chk("R10", "not yet asserted after edge 3", core_rst_n, 1'b1);
    edges(1);
    chk("R10", "below wins, asserted after edge 4", core_rst_n, 1'b0);
    chk("R10", "cause is supply", rst_cause, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    edges(N + 2);
    chk("R10", "held before stretch end", core_rst_n, 1'b0);
    edges(1);
    chk("R10", "released after stretch", core_rst_n, 1'b1);
  endtask

  initial begin
    t_reset_state;
    t_power_up;
    t_band_hold;
    t_drop;
    t_band_no_release;
    t_restart_supply;
    t_pin;
    t_pin_restart;
    t_both;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule